// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory built for a shared data bus. It takes the address and the command together on one clock edge. For a write, the data comes two enabled edges later. Between those two edges the block is already free to take the address of the next access. Reads and writes can follow each other with no idle cycle. The bus never needs a turnaround slot, because read data and write data sit in the same cycle slot relative to their commands.

The memory is organised as byte lanes. A per-lane write select masks each write, so software can update one byte without first reading the whole word. Three chip selects must all be active before an access starts. A global clock enable freezes the whole pipeline. The bus direction is brought out as `dq_oe`, which lets the pad ring or a wrapper build the tristate. Output enable acts on `dq_oe` without waiting for a clock edge.

`rst_n` is asserted asynchronously. It is expected to arrive already synchronised to `clk` on its deassertion. The storage array itself is not reset.

Top module: `lwsram_core`

## Requirements
- R1: An access starts on a rising edge only if `cen_n`=0, `cs0_n`=0, `cs1`=1 and `cs2_n`=0. It is a write when `we_n`=0 and a read when `we_n`=1. If any select is inactive, the edge issues no access and the memory is unchanged.
- R2: For a write taken at enabled edge k, `dq_in` is sampled at enabled edge k+2 and stored at the address captured at edge k.
- R3: Byte lane i is bits [8i+7:8i]. Lane i is written only when `bw_n[i]`=0 at the command edge. Lanes whose select is 1 keep their previous contents.
- R4: For a read taken at enabled edge k, the stored word appears on `dq_out` after enabled edge k+1. It stays there until edge k+2, where the host samples it.
- R5: `dq_oe` is 1 only while a read is in its data phase and `oe_n`=0. It is 0 throughout a write's data phase, whatever the level of `oe_n`.
- R6: `oe_n`=1 forces `dq_oe` to 0 with no clock edge needed.
- R7: While `cen_n`=1, no pipeline stage advances, the memory is not written, and `dq_out`/`dq_oe` keep their data phase.
- R8: A new command is accepted on every enabled edge, including the edge between a write's command and its data. Commands complete in issue order.
- R9: A read issued on the enabled edge right after a write to the same address returns the write's new bytes merged over the old word, lane by lane.
- R10: During and right after reset, no access is pending, `dq_oe`=0 and `dq_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable for the whole pipeline |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write command, 1 = read command |
| bw_n | input | LANES | Active-low per-byte write selects |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_in | input | 8*LANES | Bus value seen by the block (write data) |
| dq_out | output | 8*LANES | Read data toward the bus |
| dq_oe | output | 1 | 1 = block drives the bus |

## Verification
The assertions check four things on every cycle: command decode into the first stage, in-order advance between stages, the total freeze under a high clock enable, and the rules that keep `dq_oe` low during write data phases and whenever output enable is high. The values that come back from memory can only be shown by the bench's scenarios, because they depend on the whole command history. Those scenarios cover byte-masked merging, the forwarding of a write that is still pending into an immediately following read, deselected commands that must leave memory alone, and stalls inside a write's data phase.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  // Kind of access carried by a pipeline stage.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;

  // Number of enabled edges from command to data sample (protocol fixed).
  localparam int unsigned LW_LATENCY = 2;

endpackage

// File: rtl/lwsram_decode.sv
module lwsram_decode
  import lwsram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  output lw_op_e           op,
  output logic [LANES-1:0] lane_en
);

  logic selected;

  always_comb begin
    selected = !cs0_n && cs1 && !cs2_n;
    if (!selected)  op = OP_IDLE;
    else if (we_n)  op = OP_READ;
    else            op = OP_WRITE;
    lane_en = ~bw_n;
  end

endmodule

// File: rtl/lwsram_stage.sv
module lwsram_stage
  import lwsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  lw_op_e            op_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [LANES-1:0]  lane_d,
  output lw_op_e            op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  lane_q
);

  lw_op_e            op_n;
  logic [ADDR_W-1:0] addr_n;
  logic [LANES-1:0]  lane_n;

  always_comb begin
    op_n   = op_q;
    addr_n = addr_q;
    lane_n = lane_q;
    if (adv) begin
      op_n   = op_d;
      addr_n = addr_d;
      lane_n = lane_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      lane_q <= '0;
    end else begin
      op_q   <= op_n;
      addr_q <= addr_n;
      lane_q <= lane_n;
    end
  end

endmodule

// File: rtl/lwsram_merge.sv
module lwsram_merge #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] base_w,
  input  logic [8*LANES-1:0] upd_w,
  input  logic [LANES-1:0]   lane_en,
  output logic [8*LANES-1:0] out_w
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign out_w[8*i +: 8] = lane_en[i] ? upd_w[8*i +: 8] : base_w[8*i +: 8];
  end

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [LANES-1:0]    wr_lane,
  input  logic [8*LANES-1:0]  wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [8*LANES-1:0]  rd_data
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = 8 * LANES;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lane[i]) store[wr_addr][8*i +: 8] <= wr_data[8*i +: 8];
      end
    end
  end

  assign rd_data = store[rd_addr];

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cen_n,
  input  logic                cs0_n,
  input  logic                cs1,
  input  logic                cs2_n,
  input  logic                we_n,
  input  logic [LANES-1:0]    bw_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [8*LANES-1:0]  dq_in,
  output logic [8*LANES-1:0]  dq_out,
  output logic                dq_oe
);

  localparam int unsigned DATA_W = 8 * LANES;
  localparam int unsigned NSTAGE = LW_LATENCY;

  logic              adv;
  lw_op_e            dec_op;
  logic [LANES-1:0]  dec_lane;

  lw_op_e            op_q   [NSTAGE];
  logic [ADDR_W-1:0] addr_q [NSTAGE];
  logic [LANES-1:0]  lane_q [NSTAGE];

  lw_op_e            s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s2_lane;

  logic [DATA_W-1:0] arr_rd, fwd_word, rd_word;
  logic              arr_we, fwd_hit;
  logic [DATA_W-1:0] dout_n, dout_q;

  assign adv = !cen_n;

  lwsram_decode #(.LANES(LANES)) u_decode (
    .cs0_n  (cs0_n),
    .cs1    (cs1),
    .cs2_n  (cs2_n),
    .we_n   (we_n),
    .bw_n   (bw_n),
    .op     (dec_op),
    .lane_en(dec_lane)
  );

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k == 0) begin : g_head
      lwsram_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .op_d  (dec_op),
        .addr_d(addr),
        .lane_d(dec_lane),
        .op_q  (op_q[k]),
        .addr_q(addr_q[k]),
        .lane_q(lane_q[k])
      );
    end else begin : g_tail
      lwsram_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .op_d  (op_q[k-1]),
        .addr_d(addr_q[k-1]),
        .lane_d(lane_q[k-1]),
        .op_q  (op_q[k]),
        .addr_q(addr_q[k]),
        .lane_q(lane_q[k])
      );
    end
  end

  assign s1_op   = op_q[0];
  assign s1_addr = addr_q[0];
  assign s2_op   = op_q[NSTAGE-1];
  assign s2_addr = addr_q[NSTAGE-1];
  assign s2_lane = lane_q[NSTAGE-1];

  // Write commit: the word on the bus is taken when the write leaves stage 2.
  assign arr_we = adv && (s2_op == OP_WRITE);

  lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk    (clk),
    .wr_en  (arr_we),
    .wr_addr(s2_addr),
    .wr_lane(s2_lane),
    .wr_data(dq_in),
    .rd_addr(s1_addr),
    .rd_data(arr_rd)
  );

  // A read leaving stage 1 sees the write committing on the same edge.
  lwsram_merge #(.LANES(LANES)) u_fwd (
    .base_w (arr_rd),
    .upd_w  (dq_in),
    .lane_en(s2_lane),
    .out_w  (fwd_word)
  );

  always_comb begin
    fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);
    rd_word = fwd_hit ? fwd_word : arr_rd;
    dout_n  = dout_q;
    if (adv && (s1_op == OP_READ)) dout_n = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_n;
  end

  assign dq_out = dout_q;
  assign dq_oe  = (s2_op == OP_READ) && !oe_n;

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk
  import lwsram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cen_n,
  input logic               cs0_n,
  input logic               cs1,
  input logic               cs2_n,
  input logic               we_n,
  input logic               oe_n,
  input logic [8*LANES-1:0] dq_out,
  input logic               dq_oe,
  input lw_op_e             s1_op,
  input lw_op_e             s2_op
);

  assert_write_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !cs0_n && cs1 && !cs2_n && !we_n) |=> (s1_op == OP_WRITE));

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && (cs0_n || !cs1 || cs2_n)) |=> (s1_op == OP_IDLE));

  assert_in_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cen_n |=> (s2_op == $past(s1_op)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(dq_out)));

  assert_write_phase_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_op == OP_WRITE) |-> !dq_oe);

  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

endmodule

bind lwsram_core lwsram_chk #(.LANES(LANES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cen_n (cen_n),
  .cs0_n (cs0_n),
  .cs1   (cs1),
  .cs2_n (cs2_n),
  .we_n  (we_n),
  .oe_n  (oe_n),
  .dq_out(dq_out),
  .dq_oe (dq_oe),
  .s1_op (s1_op),
  .s2_op (s2_op)
);

// File: tb/lwsram_core_bench.sv
`timescale 1ns/1ps
module lwsram_core_bench;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cen_n, cs0_n, cs1, cs2_n, we_n, oe_n;
  logic [LANES-1:0]  bw_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dq_in, dq_out;
  logic              dq_oe;

  always #2 clk = ~clk;

  lwsram_core #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lwsram_core (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Model: 0 idle, 1 read, 2 write
  logic [DATA_W-1:0] ref_mem [DEPTH];
  int                p1_op = 0, p2_op = 0;
  logic [ADDR_W-1:0] p1_addr, p2_addr;
  logic [LANES-1:0]  p1_bwn, p2_bwn;
  logic [DATA_W-1:0] p1_data, p2_data, p2_exp;
  bit                p2_fwd = 0;
  string             tag = "R4";

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
      input logic [DATA_W-1:0] new_w, input logic [LANES-1:0] wbn);
    logic [DATA_W-1:0] r = old_w;
    for (int i = 0; i < LANES; i++) if (!wbn[i]) r[8*i +: 8] = new_w[8*i +: 8];
    return r;
  endfunction

  task automatic step(input bit cen, input bit c0n, input bit c1, input bit c2n,
      input bit wen, input logic [LANES-1:0] wbn, input bit oen,
      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
    int nop;
    @(negedge clk);
    cen_n = cen; cs0_n = c0n; cs1 = c1; cs2_n = c2n; we_n = wen;
    bw_n = wbn; oe_n = oen; addr = a;
    dq_in = (p2_op == 2) ? p2_data : DATA_W'($urandom);
    #1;
    if (p2_op == 1) begin
      chk({tag, " R5 R6 dq_oe in read phase"}, 64'(dq_oe), 64'(!oen));
      chk({tag, p2_fwd ? " R9 forwarded read" : " R4 read data", cen ? " R7 stalled" : ""},
          64'(dq_out), 64'(p2_exp));
    end else begin
      chk({tag, " R5 dq_oe off outside read phase"}, 64'(dq_oe), 64'd0);
    end
    @(posedge clk);
    if (!cen) begin
      if (p2_op == 2) ref_mem[p2_addr] = merge(ref_mem[p2_addr], p2_data, p2_bwn);
      p2_fwd  = (p2_op == 2) && (p1_op == 1) && (p2_addr == p1_addr);
      p2_op   = p1_op; p2_addr = p1_addr; p2_bwn = p1_bwn; p2_data = p1_data;
      p2_exp  = ref_mem[p1_addr];
      nop = (!c0n && c1 && !c2n) ? (wen ? 1 : 2) : 0;
      p1_op = nop; p1_addr = a; p1_bwn = wbn; p1_data = wd;
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] wbn,
      input logic [DATA_W-1:0] d);
    step(0, 0, 1, 0, 0, wbn, 0, a, d);
  endtask
  task automatic rd(input logic [ADDR_W-1:0] a, input bit oen);
    step(0, 0, 1, 0, 1, '1, oen, a, '0);
  endtask
  task automatic idle();
    step(0, 1, 0, 1, 1, '1, 0, '0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1a7e5eed));
    rst_n = 0; cen_n = 0; cs0_n = 1; cs1 = 0; cs2_n = 1; we_n = 1;
    bw_n = '1; oe_n = 0; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 dq_oe in reset", 64'(dq_oe), 64'd0);
    chk("R10 dq_out in reset", 64'(dq_out), 64'd0);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R10 dq_oe after reset", 64'(dq_oe), 64'd0);
    chk("R10 dq_out after reset", 64'(dq_out), 64'd0);

    // R2: fill the low addresses with full-word writes, back to back
    tag = "R2";
    for (int i = 0; i < 8; i++) wr(ADDR_W'(i), '0, {4{8'(i * 17 + 3)}});
    idle(); idle();
    for (int i = 0; i < 8; i++) rd(ADDR_W'(i), 0);
    idle(); idle();

    // R3: partial lanes, read after a gap
    tag = "R3";
    wr(6'd2, 4'b1010, 32'hA1B2C3D4);
    idle(); idle();
    rd(6'd2, 0); idle(); idle();

    // R9: read right behind a masked write to the same address
    tag = "R9";
    wr(6'd3, 4'b0110, 32'h11223344);
    rd(6'd3, 0);
    idle(); idle();

    // R1: each select inactive in turn must block the write
    tag = "R1";
    step(0, 1, 1, 0, 0, '0, 0, 6'd4, 32'hDEAD0001);
    step(0, 0, 0, 0, 0, '0, 0, 6'd4, 32'hDEAD0002);
    step(0, 0, 1, 1, 0, '0, 0, 6'd4, 32'hDEAD0003);
    idle(); idle();
    rd(6'd4, 0); idle(); idle();

    // R6: read with output enable high
    tag = "R6";
    rd(6'd5, 1); idle(); idle();

    // R7: stall inside a write data phase and inside a read data phase
    tag = "R7";
    wr(6'd6, '0, 32'h600DF00D);
    idle();
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, '0, 0, 6'd7, 32'hBAD0BAD0);
    idle();
    rd(6'd6, 0); idle();
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, '0, 0, 6'd6, 32'hBAD1BAD1);
    idle(); idle();

    // R8: read-write-read back to back on one address
    tag = "R8";
    rd(6'd1, 0); wr(6'd1, 4'b1100, 32'h55667788); rd(6'd1, 0);
    idle(); idle();

    // Random traffic
    tag = "R4";
    for (int n = 0; n < 2500; n++) begin
      bit cen, c0n, c1, c2n, wen, oen;
      logic [LANES-1:0] wbn;
      cen = ($urandom_range(99) < 15);
      c0n = ($urandom_range(99) < 5);
      c1  = !($urandom_range(99) < 5);
      c2n = ($urandom_range(99) < 5);
      wen = $urandom_range(1);
      wbn = ($urandom_range(99) < 30) ? '0 : LANES'($urandom);
      oen = ($urandom_range(99) < 10);
      step(cen, c0n, c1, c2n, wen, wbn, oen, ADDR_W'($urandom_range(7)), DATA_W'($urandom));
    end
    idle(); idle(); idle();
    finish_run();
  end

endmodule